// File: doc/BRIEF.md
# Cascadable Presettable Counter Stage

This block is a synchronous up counter of four bits, built in one of two forms chosen at elaboration. The binary form counts through all sixteen states. The decade form counts through ten states. A second option decides whether the active-low clear input acts at once or waits for a rising clock edge. Besides clear, the stage has an active-low preset that loads a parallel value, a plain count enable, and a chain enable.

The chain enable also qualifies the carry output. Stages can therefore be chained into a wider counter: each stage's carry output feeds both enables of the next stage, and all stages share one clock.

On a rising edge the clear input has the highest priority. Preset comes next, then counting, and the state holds otherwise. The carry output is combinational. It depends only on the chain enable and the present count.

Top module: `presettable_counter`

## Requirements
- R1: While `preset_n` is low at a rising edge (and `clear_n` is high), `count` takes the value of `preset_val` on that edge, whatever the enables are.
- R2: If `preset_n` is pulsed low between edges but is back high at the rising edge, no preset occurs and that edge behaves as a normal counting edge.
- R3: With `clear_n` and `preset_n` high, `count` advances by one at a rising edge only when `cnt_en` and `chain_en` are both 1; otherwise it holds.
- R4: In binary form (`DECADE`=0) the count runs 0,1,...,15 and advances from 15 to 0.
- R5: In decade form (`DECADE`=1) the count runs 0,1,...,9 and advances from 9 to 0.
- R6: In decade form, a preset value from 10 to 14 advances by one on the next counting edge, and 15 advances to 0.
- R7: `carry_out` is 1 exactly when `chain_en` is 1 and `count` equals the terminal value (15 binary, 9 decade), independent of `cnt_en`.
- R8: With `ASYNC_CLEAR`=1, driving `clear_n` low sets `count` to 0 immediately, without a clock edge.
- R9: With `ASYNC_CLEAR`=0, `clear_n` low changes nothing between edges, and `count` becomes 0 on the rising edge while it is low.
- R10: Clear takes precedence over preset, and preset takes precedence over counting.
- R11: Two binary stages, where the upper stage's `cnt_en` and `chain_en` are both driven by the lower stage's `carry_out`, count together as one 8-bit counter that advances from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear, asynchronous or synchronous by parameter |
| preset_n | input | 1 | Active-low parallel preset |
| preset_val | input | WIDTH | Value loaded by a preset |
| cnt_en | input | 1 | Count enable, no effect on carry |
| chain_en | input | 1 | Count enable that also qualifies the carry |
| count | output | WIDTH | Present count |
| carry_out | output | 1 | Terminal-count carry for the next stage |

## Verification
Clear, preset and counting can all be requested in the same cycle. The bench provokes this by holding `clear_n` low while `preset_n` is low and both enables are high, and then by holding preset low with both enables high. A reference model resolves each edge by priority, and the scoreboard compares the resulting count for both clear styles. A second overlap occurs at the terminal count with `cnt_en` low and `chain_en` high: the carry must be high while the count holds. The decade stage's carry is also judged against its nine-valued terminal.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_STEP   = 2'd1,
      OP_PRESET = 2'd2,
      OP_CLEAR  = 2'd3
   } cnt_op_e;

   localparam int DECADE_TERMINAL = 9;
   localparam int DECADE_WIDTH    = 4;

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
   import cnt_pkg::*;
(
   input  logic    clear_n,
   input  logic    preset_n,
   input  logic    cnt_en,
   input  logic    chain_en,
   output cnt_op_e op
);

   always_comb begin
      if (!clear_n)
         op = OP_CLEAR;
      else if (!preset_n)
         op = OP_PRESET;
      else if (cnt_en && chain_en)
         op = OP_STEP;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/cnt_next_value.sv
module cnt_next_value
   import cnt_pkg::*;
#(
   parameter int               WIDTH    = 4,
   parameter logic [WIDTH-1:0] TERMINAL = '1
) (
   input  cnt_op_e          op,
   input  logic [WIDTH-1:0] count,
   input  logic [WIDTH-1:0] preset_val,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ALL_ONES = '1;

   logic             at_wrap;
   logic [WIDTH-1:0] stepped;

   // Wrap at the terminal value, and also from the top code so that any
   // out-of-sequence state drifts back into the normal sequence.
   assign at_wrap = (count == TERMINAL) || (count == ALL_ONES);
   assign stepped = at_wrap ? '0 : count + WIDTH'(1);

   always_comb begin
      unique case (op)
         OP_CLEAR:  nxt = '0;
         OP_PRESET: nxt = preset_val;
         OP_STEP:   nxt = stepped;
         default:   nxt = count;
      endcase
   end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
   parameter int WIDTH       = 4,
   parameter bit ASYNC_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);

   generate
      if (ASYNC_CLEAR) begin : g_async
         always_ff @(posedge clk or negedge clear_n) begin
            if (!clear_n)
               q <= '0;
            else
               q <= nxt;
         end
      end else begin : g_sync
         // The clear is resolved by the next-value logic at the edge.
         always_ff @(posedge clk) begin
            q <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/cnt_carry_gen.sv
module cnt_carry_gen #(
   parameter int               WIDTH    = 4,
   parameter logic [WIDTH-1:0] TERMINAL = '1
) (
   input  logic [WIDTH-1:0] count,
   input  logic             chain_en,
   output logic             carry_out
);

   assign carry_out = chain_en && (count == TERMINAL);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
   import cnt_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter bit DECADE      = 1'b0,
   parameter bit ASYNC_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             preset_n,
   input  logic [WIDTH-1:0] preset_val,
   input  logic             cnt_en,
   input  logic             chain_en,
   output logic [WIDTH-1:0] count,
   output logic             carry_out
);

   localparam int               TERM_INT = DECADE ? DECADE_TERMINAL : (2 ** WIDTH) - 1;
   localparam logic [WIDTH-1:0] TERMINAL = WIDTH'(TERM_INT);

   generate
      if (WIDTH < 1 || WIDTH > 30) begin : g_bad_width
         $error("presettable_counter: WIDTH out of range");
      end
      if (DECADE && WIDTH != DECADE_WIDTH) begin : g_bad_decade
         $error("presettable_counter: decade form needs a 4-bit width");
      end
   endgenerate

   cnt_op_e          op;
   logic [WIDTH-1:0] nxt;

   cnt_op_decode u_decode (
      .clear_n  (clear_n),
      .preset_n (preset_n),
      .cnt_en   (cnt_en),
      .chain_en (chain_en),
      .op       (op)
   );

   cnt_next_value #(
      .WIDTH    (WIDTH),
      .TERMINAL (TERMINAL)
   ) u_next (
      .op         (op),
      .count      (count),
      .preset_val (preset_val),
      .nxt        (nxt)
   );

   cnt_state_reg #(
      .WIDTH       (WIDTH),
      .ASYNC_CLEAR (ASYNC_CLEAR)
   ) u_state (
      .clk     (clk),
      .clear_n (clear_n),
      .nxt     (nxt),
      .q       (count)
   );

   cnt_carry_gen #(
      .WIDTH    (WIDTH),
      .TERMINAL (TERMINAL)
   ) u_carry (
      .count     (count),
      .chain_en  (chain_en),
      .carry_out (carry_out)
   );

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
   parameter int WIDTH       = 4,
   parameter bit DECADE      = 1'b0,
   parameter bit ASYNC_CLEAR = 1'b1
) (
   input logic             clk,
   input logic             clear_n,
   input logic             preset_n,
   input logic [WIDTH-1:0] preset_val,
   input logic             cnt_en,
   input logic             chain_en,
   input logic [WIDTH-1:0] count,
   input logic             carry_out
);

   localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : '1;
   localparam logic [WIDTH-1:0] TOP  = '1;

   p_preset_r1: assert property (@(posedge clk) disable iff (!clear_n)
      !preset_n |=> count == $past(preset_val));

   p_hold_r3: assert property (@(posedge clk) disable iff (!clear_n)
      (preset_n && !(cnt_en && chain_en)) |=> $stable(count));

   p_carry_gate_r7: assert property (@(posedge clk) disable iff (!clear_n)
      !chain_en |-> !carry_out);

   p_carry_term_r7: assert property (@(posedge clk) disable iff (!clear_n)
      carry_out |-> count == TERM);

   generate
      if (!DECADE) begin : g_bin
         p_wrap_r4: assert property (@(posedge clk) disable iff (!clear_n)
            (preset_n && cnt_en && chain_en && count == TOP) |=> count == '0);
      end else begin : g_dec
         p_decade_range_r5: assert property (@(posedge clk) disable iff (!clear_n)
            (preset_n && count <= TERM) |=> count <= TERM);
      end
      if (ASYNC_CLEAR) begin : g_async
         p_async_clear_r8: assert property (@(posedge clk)
            !clear_n |-> count == '0);
      end else begin : g_sync
         p_sync_clear_r9: assert property (@(posedge clk)
            !clear_n |=> count == '0);
      end
   endgenerate

endmodule

bind presettable_counter presettable_counter_chk #(
   .WIDTH       (WIDTH),
   .DECADE      (DECADE),
   .ASYNC_CLEAR (ASYNC_CLEAR)
) u_chk (.*);

// File: tb/presettable_counter_bench.sv
module presettable_counter_bench;

   typedef struct {
      logic [3:0] q [4];
      logic [3:0] c;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic [3:0] clr_n = 4'b0000;
   logic [3:0] ld_n  = 4'b1111;
   logic [3:0] ep    = 4'b0000;
   logic [3:0] et    = 4'b0000;
   logic [3:0] d [4];
   logic [3:0] qv [4];
   logic [3:0] cv;

   logic [3:0] mq [4];
   logic [3:0] mc;
   exp_t       sb [$];
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   // unit 0: binary, asynchronous clear
   presettable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b1)) u_presettable_counter (
      .clk(clk), .clear_n(clr_n[0]), .preset_n(ld_n[0]), .preset_val(d[0]),
      .cnt_en(ep[0]), .chain_en(et[0]), .count(qv[0]), .carry_out(cv[0]));

   // unit 1: decade, synchronous clear
   presettable_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b0)) u_presettable_counter_dec (
      .clk(clk), .clear_n(clr_n[1]), .preset_n(ld_n[1]), .preset_val(d[1]),
      .cnt_en(ep[1]), .chain_en(et[1]), .count(qv[1]), .carry_out(cv[1]));

   // units 2 and 3: two-stage binary cascade (R11)
   presettable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) u_presettable_counter_lo (
      .clk(clk), .clear_n(clr_n[2]), .preset_n(ld_n[2]), .preset_val(d[2]),
      .cnt_en(ep[2]), .chain_en(et[2]), .count(qv[2]), .carry_out(cv[2]));

   presettable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) u_presettable_counter_hi (
      .clk(clk), .clear_n(clr_n[3]), .preset_n(ld_n[3]), .preset_val(d[3]),
      .cnt_en(cv[2]), .chain_en(cv[2]), .count(qv[3]), .carry_out(cv[3]));

   function automatic logic [3:0] mdl_next(logic [3:0] q, bit dec, logic c_n, logic l_n,
                                           logic [3:0] dv, logic p, logic t);
      if (!c_n) return 4'd0;
      if (!l_n) return dv;
      if (p && t) begin
         if (dec) return (q == 4'd9 || q == 4'd15) ? 4'd0 : q + 4'd1;
         return q + 4'd1;
      end
      return q;
   endfunction

   task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Driver: inputs are already set; compute expectations, queue them, wait one cycle.
   task automatic step(string tag);
      exp_t       it;
      logic [3:0] nq [4];
      nq[0] = mdl_next(mq[0], 1'b0, clr_n[0], ld_n[0], d[0], ep[0], et[0]);
      nq[1] = mdl_next(mq[1], 1'b1, clr_n[1], ld_n[1], d[1], ep[1], et[1]);
      nq[2] = mdl_next(mq[2], 1'b0, clr_n[2], ld_n[2], d[2], ep[2], et[2]);
      nq[3] = mdl_next(mq[3], 1'b0, clr_n[3], ld_n[3], d[3], mc[2], mc[2]);
      for (int u = 0; u < 4; u++) mq[u] = nq[u];
      mc[0] = et[0] && mq[0] == 4'd15;
      mc[1] = et[1] && mq[1] == 4'd9;
      mc[2] = et[2] && mq[2] == 4'd15;
      mc[3] = mc[2] && mq[3] == 4'd15;
      for (int u = 0; u < 4; u++) it.q[u] = mq[u];
      it.c   = mc;
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
   endtask

   // Monitor: compare each queued expectation shortly after its edge.
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         for (int u = 0; u < 4; u++) begin
            check($sformatf("%s unit%0d count", it.tag, u), {1'b0, qv[u]}, {1'b0, it.q[u]});
            check($sformatf("%s unit%0d carry", it.tag, u), {4'd0, cv[u]}, {4'd0, it.c[u]});
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int u = 0; u < 4; u++) begin
         d[u]  = 4'd0;
         mq[u] = 4'd0;
      end
      mc = 4'd0;
      @(negedge clk);
      // reset state through clear (R8 R9)
      step("R8 R9 reset");
      step("R8 R9 reset");
      clr_n = 4'b1111;

      // main counting, binary and decade (R3 R4 R5)
      ep = 4'b0011; et = 4'b0011;
      for (int i = 0; i < 20; i++) step("R4 R5");
      // one enable low: hold (R3 R7)
      ep = 4'b0000; et = 4'b0011;
      for (int i = 0; i < 3; i++) step("R3 R7");
      ep = 4'b0011; et = 4'b0000;
      for (int i = 0; i < 3; i++) step("R3");

      // preset with enables high, then count past wrap (R1 R6 R4)
      ep = 4'b0011; et = 4'b0011;
      ld_n = 4'b1100; d[0] = 4'd14; d[1] = 4'd12;
      step("R1");
      ld_n = 4'b1111;
      for (int i = 0; i < 5; i++) step("R6 R4");
      ld_n = 4'b1100; d[1] = 4'd15;
      step("R1 R6");
      ld_n = 4'b1111;
      step("R6");

      // carry at terminal with cnt_en low (R7)
      ld_n = 4'b1100; d[0] = 4'd15; d[1] = 4'd9;
      step("R1");
      ld_n = 4'b1111; ep = 4'b0000; et = 4'b0011;
      step("R7");
      et = 4'b0000;
      step("R7");

      // all three requests at once, then preset versus count (R10)
      ld_n = 4'b1100; d[0] = 4'd5; d[1] = 4'd7; ep = 4'b0011; et = 4'b0011;
      clr_n = 4'b1100;
      step("R10");
      clr_n = 4'b1111;
      step("R10");
      ld_n = 4'b1111;
      step("R10");

      // preset withdrawn before the edge (R2)
      ld_n = 4'b1100; d[0] = 4'd2; d[1] = 4'd2;
      #2;
      ld_n = 4'b1111;
      step("R2");

      // clear between edges: asynchronous acts at once, synchronous waits (R8 R9)
      clr_n = 4'b1100;
      #1;
      check("R8 immediate", {1'b0, qv[0]}, 5'd0);
      check("R9 no early clear", {1'b0, qv[1]}, {1'b0, mq[1]});
      step("R8 R9");
      clr_n = 4'b1111;
      step("R8 R9");
      ep = 4'b0000; et = 4'b0000;

      // cascade (R11)
      ep[2] = 1'b1; et[2] = 1'b1;
      for (int i = 0; i < 300; i++) step("R11");
      check("R11 wide value", {1'b0, qv[3]}, {1'b0, 4'(300 >> 4)});
      ld_n = 4'b0011; d[2] = 4'd14; d[3] = 4'd15;
      step("R11 preset");
      ld_n = 4'b1111;
      for (int i = 0; i < 4; i++) step("R11 wrap");
      check("R11 wrap to zero", {1'b0, qv[3]}, 5'd0);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule